// File: doc/BRIEF.md
# Operand Bypass Selector

This block sits in the decode stage of a five-stage in-order pipeline. For each of the two source operands of the instruction now in decode, it chooses which value travels on into the execute pipeline register. That value is either the register-file read or a newer result that an older instruction has produced but not yet written back. Five candidate producers are examined in strict recency order, so the youngest producer always wins:

- the ALU result leaving the execute stage's logic in this cycle;
- the loaded value held in the memory-stage register;
- the ALU result held in the memory-stage register;
- the loaded value held in the writeback-stage register;
- the ALU result held in the writeback-stage register.

Every in-flight instruction names two destinations, one for its ALU result and one for its loaded value. Either destination may carry the reserved code meaning "no register". The execute candidate is taken straight from the combinational ALU output. This lets an instruction that directly follows its producer proceed with no bubble. The register copy in the memory stage would reach decode a cycle too late for that case.

The selection logic is purely combinational. Its two results are captured into the execute pipeline register on the rising clock edge, and that register forms the block's outputs. The register file and stall generation for load-use hazards are handled elsewhere.

Top module: `opbyp_top`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, both outputs `exr_val_a` and `exr_val_b` are zero.
- R2: When a source ID matches none of the five destination IDs, the output for that operand takes the register-file read value for that operand.
- R3: When the execute-stage ALU destination matches a source ID, that operand takes the execute ALU value. This holds even if every other candidate also matches.
- R4: If the execute stage does not match but the memory-stage load destination does, the operand takes the memory-stage load value. This holds even when the memory-stage ALU destination and the writeback destinations also match.
- R5: If neither of the above matches but the memory-stage ALU destination does, the operand takes the memory-stage ALU value, ahead of both writeback candidates.
- R6: If no execute or memory candidate matches but the writeback load destination does, the operand takes the writeback load value, ahead of the writeback ALU value.
- R7: If only the writeback ALU destination matches, the operand takes the writeback ALU value instead of the register-file read.
- R8: The reserved ID `NONE_ID` (default 4'hF, all ones) never matches. A source equal to it takes the register-file read, even when destinations also carry `NONE_ID`.
- R9: The two operands are selected independently. When both name the same register and their register-file reads agree, both outputs are equal.
- R10: The value selected from the inputs present before a rising edge appears at the outputs right after that edge and holds for one cycle. There is no further latency, and there is no combinational path from the inputs to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the execute register captures on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_src_a | input | ID_W | Source register ID of operand A in decode |
| dec_src_b | input | ID_W | Source register ID of operand B in decode |
| rf_val_a | input | DATA_W | Register-file read value for operand A |
| rf_val_b | input | DATA_W | Register-file read value for operand B |
| ex_dst_alu | input | ID_W | ALU destination of the instruction in execute |
| ex_alu_val | input | DATA_W | Combinational ALU result of the execute stage |
| mem_dst_ld | input | ID_W | Load destination in the memory-stage register |
| mem_ld_val | input | DATA_W | Loaded value in the memory stage |
| mem_dst_alu | input | ID_W | ALU destination in the memory-stage register |
| mem_alu_val | input | DATA_W | ALU result in the memory-stage register |
| wb_dst_ld | input | ID_W | Load destination in the writeback-stage register |
| wb_ld_val | input | DATA_W | Loaded value in the writeback-stage register |
| wb_dst_alu | input | ID_W | ALU destination in the writeback-stage register |
| wb_alu_val | input | DATA_W | ALU result in the writeback-stage register |
| exr_val_a | output | DATA_W | Operand A as captured into the execute register |
| exr_val_b | output | DATA_W | Operand B as captured into the execute register |

## Verification
The only state is the execute pipeline register, so a wrong stored value shows up on `exr_val_a` or `exr_val_b` right after the very edge that captured it. It is replaced one cycle later. A fault in the priority chain, the match logic or the handling of the reserved ID appears only when several producers target the same register or when the reserved code is used. For that reason the stimulus deliberately stacks matching destinations at every level of the order. A slip in the capture register, such as an extra stage or a missing one, shifts every expected value by one cycle and shows up on the first vector.

// File: rtl/opbyp_pkg.sv
`timescale 1ns/1ps
package opbyp_pkg;
    // Number of in-flight producers examined, youngest first.
    localparam int NUM_PROD = 5;
    // Number of source operands resolved per instruction.
    localparam int NUM_OPS  = 2;

    // Candidate slot positions; a lower index is younger and wins.
    typedef enum int {
        SLOT_EX_ALU  = 0,
        SLOT_MEM_LD  = 1,
        SLOT_MEM_ALU = 2,
        SLOT_WB_LD   = 3,
        SLOT_WB_ALU  = 4
    } prod_slot_e;
endpackage

// File: rtl/opbyp_match.sv
`timescale 1ns/1ps
module opbyp_match #(
    parameter int               ID_W    = 4,
    parameter logic [ID_W-1:0]  NONE_ID = '1
) (
    input  logic [ID_W-1:0] src_id,
    input  logic [ID_W-1:0] dst_id,
    output logic            hit
);
    logic src_real;

    always_comb begin
        src_real = (src_id != NONE_ID);
        hit      = src_real && (dst_id == src_id);
    end
endmodule

// File: rtl/opbyp_pick.sv
`timescale 1ns/1ps
module opbyp_pick #(
    parameter int               DATA_W  = 64,
    parameter int               ID_W    = 4,
    parameter logic [ID_W-1:0]  NONE_ID = '1,
    parameter int               N       = 5
) (
    input  logic [ID_W-1:0]             src_id,
    input  logic [N-1:0][ID_W-1:0]      dst_ids,
    input  logic [N-1:0][DATA_W-1:0]    dst_vals,
    input  logic [DATA_W-1:0]           rf_val,
    output logic [DATA_W-1:0]           pick_val
);
    logic [N-1:0] hits;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        opbyp_match #(
            .ID_W    (ID_W),
            .NONE_ID (NONE_ID)
        ) u_match (
            .src_id (src_id),
            .dst_id (dst_ids[g]),
            .hit    (hits[g])
        );
    end

    // Walk from the oldest candidate to the youngest so that the youngest
    // matching producer is the last assignment and therefore wins.
    always_comb begin
        pick_val = rf_val;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                pick_val = dst_vals[i];
            end
        end
    end
endmodule

// File: rtl/opbyp_top.sv
`timescale 1ns/1ps
module opbyp_top
    import opbyp_pkg::*;
#(
    parameter int               DATA_W  = 64,
    parameter int               ID_W    = 4,
    parameter logic [ID_W-1:0]  NONE_ID = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ID_W-1:0]     dec_src_a,
    input  logic [ID_W-1:0]     dec_src_b,
    input  logic [DATA_W-1:0]   rf_val_a,
    input  logic [DATA_W-1:0]   rf_val_b,
    input  logic [ID_W-1:0]     ex_dst_alu,
    input  logic [DATA_W-1:0]   ex_alu_val,
    input  logic [ID_W-1:0]     mem_dst_ld,
    input  logic [DATA_W-1:0]   mem_ld_val,
    input  logic [ID_W-1:0]     mem_dst_alu,
    input  logic [DATA_W-1:0]   mem_alu_val,
    input  logic [ID_W-1:0]     wb_dst_ld,
    input  logic [DATA_W-1:0]   wb_ld_val,
    input  logic [ID_W-1:0]     wb_dst_alu,
    input  logic [DATA_W-1:0]   wb_alu_val,
    output logic [DATA_W-1:0]   exr_val_a,
    output logic [DATA_W-1:0]   exr_val_b
);
    typedef struct packed {
        logic [DATA_W-1:0] val_a;
        logic [DATA_W-1:0] val_b;
    } exreg_t;

    logic [NUM_PROD-1:0][ID_W-1:0]   prod_ids;
    logic [NUM_PROD-1:0][DATA_W-1:0] prod_vals;
    logic [NUM_OPS-1:0][ID_W-1:0]    op_src;
    logic [NUM_OPS-1:0][DATA_W-1:0]  op_rf;
    logic [NUM_OPS-1:0][DATA_W-1:0]  op_pick;

    exreg_t st_d;
    exreg_t st_q;

    // Pack the producers in recency order.
    always_comb begin
        prod_ids[SLOT_EX_ALU]   = ex_dst_alu;
        prod_vals[SLOT_EX_ALU]  = ex_alu_val;
        prod_ids[SLOT_MEM_LD]   = mem_dst_ld;
        prod_vals[SLOT_MEM_LD]  = mem_ld_val;
        prod_ids[SLOT_MEM_ALU]  = mem_dst_alu;
        prod_vals[SLOT_MEM_ALU] = mem_alu_val;
        prod_ids[SLOT_WB_LD]    = wb_dst_ld;
        prod_vals[SLOT_WB_LD]   = wb_ld_val;
        prod_ids[SLOT_WB_ALU]   = wb_dst_alu;
        prod_vals[SLOT_WB_ALU]  = wb_alu_val;
        op_src[0]               = dec_src_a;
        op_src[1]               = dec_src_b;
        op_rf[0]                = rf_val_a;
        op_rf[1]                = rf_val_b;
    end

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
        opbyp_pick #(
            .DATA_W  (DATA_W),
            .ID_W    (ID_W),
            .NONE_ID (NONE_ID),
            .N       (NUM_PROD)
        ) u_pick (
            .src_id   (op_src[op]),
            .dst_ids  (prod_ids),
            .dst_vals (prod_vals),
            .rf_val   (op_rf[op]),
            .pick_val (op_pick[op])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.val_a = op_pick[0];
        st_d.val_b = op_pick[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exr_val_a = st_q.val_a;
    assign exr_val_b = st_q.val_b;

    // Assertions on port behaviour across the capture edge.
    p_ex_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src_a != NONE_ID && ex_dst_alu == dec_src_a)
        |=> (exr_val_a == $past(ex_alu_val)));

    p_memld_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src_b != NONE_ID && ex_dst_alu != dec_src_b && mem_dst_ld == dec_src_b)
        |=> (exr_val_b == $past(mem_ld_val)));

    p_none_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src_a == NONE_ID) |=> (exr_val_a == $past(rf_val_a)));

    p_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst_alu != dec_src_b && mem_dst_ld != dec_src_b &&
         mem_dst_alu != dec_src_b && wb_dst_ld != dec_src_b &&
         wb_dst_alu != dec_src_b)
        |=> (exr_val_b == $past(rf_val_b)));

    p_same_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src_a == dec_src_b && rf_val_a == rf_val_b)
        |=> (exr_val_a == exr_val_b));

    p_wb_alu_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src_a != NONE_ID && wb_dst_alu == dec_src_a &&
         ex_dst_alu != dec_src_a && mem_dst_ld != dec_src_a &&
         mem_dst_alu != dec_src_a && wb_dst_ld != dec_src_a)
        |=> (exr_val_a == $past(wb_alu_val)));
endmodule

// File: tb/opbyp_top_tb.sv
`timescale 1ns/1ps
module opbyp_top_tb;
    localparam int DW = 64;
    localparam int IW = 4;
    localparam logic [IW-1:0] NONE = 4'hF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IW-1:0] src_a, src_b, ex_d, ml_d, ma_d, wl_d, wa_d;
    logic [DW-1:0] rf_a, rf_b, ex_v, ml_v, ma_v, wl_v, wa_v;
    logic [DW-1:0] out_a, out_b;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        string         tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    opbyp_top #(.DATA_W(DW), .ID_W(IW), .NONE_ID(NONE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .dec_src_a(src_a), .dec_src_b(src_b),
        .rf_val_a(rf_a), .rf_val_b(rf_b),
        .ex_dst_alu(ex_d), .ex_alu_val(ex_v),
        .mem_dst_ld(ml_d), .mem_ld_val(ml_v),
        .mem_dst_alu(ma_d), .mem_alu_val(ma_v),
        .wb_dst_ld(wl_d), .wb_ld_val(wl_v),
        .wb_dst_alu(wa_d), .wb_alu_val(wa_v),
        .exr_val_a(out_a), .exr_val_b(out_b)
    );

    // Reference model written from the priority order in the requirements.
    function automatic logic [DW-1:0] expect_val(input logic [IW-1:0] s, input logic [DW-1:0] rf);
        if (s == NONE)      return rf;
        else if (ex_d == s) return ex_v;
        else if (ml_d == s) return ml_v;
        else if (ma_d == s) return ma_v;
        else if (wl_d == s) return wl_v;
        else if (wa_d == s) return wa_v;
        else                return rf;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_dests();
        ex_d = NONE; ml_d = NONE; ma_d = NONE; wl_d = NONE; wa_d = NONE;
    endtask

    // Driver: called right after a falling edge with inputs already set.
    task automatic push(input string tag);
        item_t it;
        it.a   = expect_val(src_a, rf_a);
        it.b   = expect_val(src_b, rf_b);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: one scoreboard item per capture edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check({it.tag, " A"}, out_a, it.a);
            check({it.tag, " B"}, out_b, it.b);
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        src_a = 4'd0; src_b = 4'd0;
        rf_a = '0; rf_b = '0;
        clear_dests();
        ex_v = 64'h1; ml_v = 64'h2; ma_v = 64'h3; wl_v = 64'h4; wa_v = 64'h5;
        rf_a = 64'hAAAA; rf_b = 64'hBBBB;
        src_a = 4'd1; src_b = 4'd1; ex_d = 4'd1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset A", out_a, '0);
        check("R1 reset B", out_b, '0);

        @(negedge clk);
        rst_n = 1'b1;
        clear_dests();
        src_a = 4'd2; src_b = 4'd3;
        rf_a = 64'h1111_0000; rf_b = 64'h2222_0000;
        push("R2 no match");

        @(negedge clk);
        ex_d = 4'd2; ml_d = 4'd2; ma_d = 4'd2; wl_d = 4'd2; wa_d = 4'd2;
        ex_v = 64'hE0E0; ml_v = 64'hD1D1; ma_v = 64'hA2A2; wl_v = 64'hB3B3; wa_v = 64'hC4C4;
        src_a = 4'd2; src_b = 4'd7;
        push("R3 execute wins");

        @(negedge clk);
        ex_d = 4'd9;
        push("R4 mem load wins");

        @(negedge clk);
        ml_d = 4'd8;
        push("R5 mem alu wins");

        @(negedge clk);
        ma_d = 4'd6;
        push("R6 wb load wins");

        @(negedge clk);
        wl_d = 4'd5;
        push("R7 wb alu wins");

        @(negedge clk);
        src_a = NONE; src_b = NONE;
        ex_d = NONE; ml_d = NONE; ma_d = NONE; wl_d = NONE; wa_d = NONE;
        rf_a = 64'h5A5A; rf_b = 64'hA5A5;
        push("R8 reserved id");

        @(negedge clk);
        clear_dests();
        src_a = 4'd4; src_b = 4'd4;
        rf_a = 64'h7777; rf_b = 64'h7777;
        ma_d = 4'd4; wa_d = 4'd4;
        push("R9 same register");

        @(negedge clk);
        src_a = 4'd3; src_b = 4'd0;
        ml_d = 4'd3; wa_d = 4'd0; ma_d = NONE;
        rf_a = 64'h1; rf_b = 64'h2;
        push("R9 independent operands");

        // Back-to-back changing vectors: each must appear after exactly one edge.
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            clear_dests();
            src_a = 4'(k); src_b = 4'(k + 1);
            ex_d = 4'(k);
            ex_v = 64'(k) * 64'h0101_0101 + 64'h10;
            rf_a = 64'(k) + 64'h100; rf_b = 64'(k) + 64'h200;
            push("R10 one cycle latency");
        end

        lfsr = 16'hACE1;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            src_a = (lfsr[3:0] == 4'd15) ? NONE : {2'b00, lfsr[1:0]};
            src_b = {2'b00, lfsr[3:2]};
            ex_d  = lfsr[4] ? {2'b00, lfsr[6:5]} : NONE;
            ml_d  = {2'b00, lfsr[8:7]};
            ma_d  = {2'b00, lfsr[10:9]};
            wl_d  = lfsr[11] ? {2'b00, lfsr[13:12]} : NONE;
            wa_d  = {2'b00, lfsr[15:14]};
            ex_v = {48'h0, lfsr} ^ 64'h1000; ml_v = {48'h0, lfsr} ^ 64'h2000;
            ma_v = {48'h0, lfsr} ^ 64'h3000; wl_v = {48'h0, lfsr} ^ 64'h4000;
            wa_v = {48'h0, lfsr} ^ 64'h5000;
            rf_a = {48'h0, lfsr} ^ 64'h6000; rf_b = {48'h0, lfsr} ^ 64'h7000;
            push("R3 R4 R5 R6 R7 mixed priority");
        end

        repeat (3) @(posedge clk);
        #1;
        if (sb_q.size() != 0) begin
            check("R10 scoreboard drained", 64'(sb_q.size()), 64'd0);
        end
        done = 1'b1;
        report();
        $finish;
    end
endmodule